// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes a set of interrupt input pins to a single delivery request port. A host reaches every internal 32-bit register through two bus locations. It first writes a register number into an index location and then reads or writes that register through a data location. The internal registers are an identification word, a read-only version and capacity word, an arbitration word, and a redirection table with one 64-bit entry (a low and a high word) per input pin.

Each entry sets the pin's polarity, its edge or level sensing and its mask. It also holds the vector, the delivery mode, the destination mode and the destination that travel with a request. The block senses the pins, keeps a pending flag per entry (visible as the delivery-status bit), and serves pending entries one at a time, lowest pin first. It does this through a two-state dispatcher. In `ST_IDLE` it picks the lowest pending pin and captures that pin's delivery fields (transition IDLE→SEND, when any entry is pending). In `ST_SEND` it holds the request until the consumer's ready handshake (transition SEND→IDLE, on ready). Level-sensed entries then stay blocked by a remote-pending bit until an end-of-interrupt message with a matching vector clears it.

Top module: `irq_router`

## Requirements
- R1: Bus offset 0x00 is the index location (its bits 7:0 hold the register number and read back as written) and offset 0x10 is the data location. Register 0x00 (controller ID) and register 0x02 (arbitration ID) keep only bits 27:24 of a write, read zero elsewhere, and reset to zero.
- R2: Register 0x01 is read-only. It returns the version parameter in bits 7:0 and the pin count minus one in bits 23:16, with all other bits zero, and host writes to it have no effect.
- R3: The entry for pin n has its low word at register 0x10+2n and its high word at 0x11+2n. The high word keeps only the destination in bits 31:24. After reset every low word reads 0x00010000 (masked) and every high word reads zero.
- R4: Low-word layout: vector 7:0, delivery mode 10:8, destination mode 11 (1 = logical), delivery status 12, polarity 13 (1 = active low), remote pending 14, trigger 15 (1 = level), mask 16. Bits 12 and 14 are read-only and host writes to them are ignored.
- R5: An edge-triggered entry records one request for each inactive-to-active transition of its pin, with the polarity bit applied.
- R6: A recorded request sets the delivery-status bit. The block raises req_valid with the entry's vector, mode, destination mode and destination, and keeps all of them unchanged until req_ready is seen high. That handshake clears the delivery-status bit.
- R7: A level-triggered entry requests while its pin is active and remote pending is clear. The handshake sets remote pending, and no further request follows while it stays set.
- R8: While the mask bit is 1, pin transitions are discarded and not remembered after unmasking, and the delivery-status bit stays clear.
- R9: An end-of-interrupt input (eoi_valid with eoi_vector) clears remote pending on every level-triggered entry whose vector equals eoi_vector, and leaves other entries unchanged.
- R10: When several entries are pending, the lowest pin number is served first. Only one request is outstanding at a time, and req_valid is low for at least one cycle after each handshake.
- R11: The 3-bit delivery mode (0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT, 7 external; 3 and 6 reserved) is carried unchanged on req_dmode, including the reserved codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write when high, read when low |
| bus_addr | input | 5 | Host byte offset (0x00 index, 0x10 data) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_vector | output | 8 | Vector of the request |
| req_dmode | output | 3 | Delivery mode of the request |
| req_dlogical | output | 1 | Destination mode (1 = logical) |
| req_dest | output | 8 | Destination of the request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
The bench writes 1s into the read-only status bits and the version register. A design that let those writes through would read back a changed word. It toggles a masked pin and then unmasks it, which catches a design that latches the event anyway and delivers it late. A level-sensed pin is held active across its handshake and across a non-matching end-of-interrupt, so a design that fails to gate on remote pending or that clears on the wrong vector produces an extra delivery. Two pins are made pending together while ready is withheld: reversed priority shows up as deliveries out of queue order.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } disp_state_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       act_low;
        logic       dst_logical;
        logic [2:0] dmode;
        logic [7:0] vector;
    } redir_cfg_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       dst_logical;
        logic [7:0] dest;
    } deliv_t;

    localparam redir_cfg_t CFG_RESET = '{
        dest: 8'h00, mask: 1'b1, level: 1'b0, act_low: 1'b0,
        dst_logical: 1'b0, dmode: 3'd0, vector: 8'h00
    };

    localparam logic [4:0] OFS_INDEX = 5'h00;
    localparam logic [4:0] OFS_DATA  = 5'h10;
    localparam logic [7:0] REG_ID    = 8'h00;
    localparam logic [7:0] REG_VER   = 8'h01;
    localparam logic [7:0] REG_ARB   = 8'h02;
    localparam logic [7:0] REG_TBL   = 8'h10;

endpackage

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
    import irq_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        pin_in,
    input  logic        eoi_valid,
    input  logic [7:0]  eoi_vector,
    input  logic        grant,
    output redir_cfg_t  cfg,
    output logic        pend,
    output logic        rirr,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi
);

    logic act, act_q, edge_evt, set_req, eoi_hit;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[23:17], wdata[14], wdata[12]};

    assign act      = pin_in ^ cfg.act_low;
    assign edge_evt = act & ~act_q;
    assign set_req  = !cfg.mask && (cfg.level ? (act && !rirr && !pend) : edge_evt);
    assign eoi_hit  = eoi_valid && cfg.level && (eoi_vector == cfg.vector);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (wr_lo) begin
                cfg.vector      <= wdata[7:0];
                cfg.dmode       <= wdata[10:8];
                cfg.dst_logical <= wdata[11];
                cfg.act_low     <= wdata[13];
                cfg.level       <= wdata[15];
                cfg.mask        <= wdata[16];
            end
            if (wr_hi) begin
                cfg.dest <= wdata[31:24];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            pend  <= 1'b0;
            rirr  <= 1'b0;
        end else begin
            act_q <= act;
            if (set_req) begin
                pend <= 1'b1;
            end else if (grant) begin
                pend <= 1'b0;
            end
            if (grant && cfg.level) begin
                rirr <= 1'b1;
            end else if (eoi_hit) begin
                rirr <= 1'b0;
            end
        end
    end

    assign rd_lo = {15'b0, cfg.mask, cfg.level, rirr, cfg.act_low, pend,
                    cfg.dst_logical, cfg.dmode, cfg.vector};
    assign rd_hi = {cfg.dest, 24'b0};

endmodule

// File: rtl/irq_host_window.sv
module irq_host_window
    import irq_router_pkg::*;
#(
    parameter int         NUM_PINS = 4,
    parameter logic [7:0] VERSION  = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [31:0]         ent_lo [NUM_PINS],
    input  logic [31:0]         ent_hi [NUM_PINS],
    output logic [NUM_PINS-1:0] wr_lo,
    output logic [NUM_PINS-1:0] wr_hi
);

    localparam logic [8:0] TBL_END  = 9'(16 + 2 * NUM_PINS);
    localparam logic [7:0] MAX_PIN  = 8'(NUM_PINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, MAX_PIN, 8'h00, VERSION};

    logic [7:0]  idx_q;
    logic [3:0]  id_q, arb_q;
    logic        idx_wr, data_wr, in_tbl;
    logic [7:0]  tbl_off;
    logic [6:0]  tbl_pin;
    logic [31:0] tbl_lo, tbl_hi, data_rd;
    logic        unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[23:8]};

    assign idx_wr  = bus_sel && bus_wr && (bus_addr == OFS_INDEX);
    assign data_wr = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign in_tbl  = (idx_q >= REG_TBL) && ({1'b0, idx_q} < TBL_END);
    assign tbl_off = idx_q - REG_TBL;
    assign tbl_pin = tbl_off[7:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
            id_q  <= 4'h0;
            arb_q <= 4'h0;
        end else begin
            if (idx_wr) begin
                idx_q <= bus_wdata[7:0];
            end
            if (data_wr && idx_q == REG_ID) begin
                id_q <= bus_wdata[27:24];
            end
            if (data_wr && idx_q == REG_ARB) begin
                arb_q <= bus_wdata[27:24];
            end
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_wr
        assign wr_lo[i] = data_wr && in_tbl && (tbl_pin == 7'(i)) && !tbl_off[0];
        assign wr_hi[i] = data_wr && in_tbl && (tbl_pin == 7'(i)) &&  tbl_off[0];
    end

    always_comb begin
        tbl_lo = '0;
        tbl_hi = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (tbl_pin == 7'(i)) begin
                tbl_lo = ent_lo[i];
                tbl_hi = ent_hi[i];
            end
        end
    end

    always_comb begin
        if (in_tbl) begin
            data_rd = tbl_off[0] ? tbl_hi : tbl_lo;
        end else if (idx_q == REG_ID) begin
            data_rd = {4'h0, id_q, 24'h0};
        end else if (idx_q == REG_VER) begin
            data_rd = VER_WORD;
        end else if (idx_q == REG_ARB) begin
            data_rd = {4'h0, arb_q, 24'h0};
        end else begin
            data_rd = '0;
        end
    end

    always_comb begin
        if (bus_addr == OFS_INDEX) begin
            bus_rdata = {24'h0, idx_q};
        end else if (bus_addr == OFS_DATA) begin
            bus_rdata = data_rd;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PIN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pend,
    input  redir_cfg_t          cfg [NUM_PINS],
    input  logic                req_ready,
    output logic                req_valid,
    output deliv_t              req,
    output logic [NUM_PINS-1:0] grant,
    output logic [PIN_W-1:0]    sel
);

    disp_state_t state_q, state_d;
    logic [PIN_W-1:0] first;
    logic             any;

    always_comb begin
        first = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                first = PIN_W'(i);
            end
        end
        any = |pend;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any)       state_d = ST_SEND;
            ST_SEND: if (req_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= '0;
            req <= '0;
        end else if (state_q == ST_IDLE && any) begin
            sel             <= first;
            req.vector      <= cfg[first].vector;
            req.dmode       <= cfg[first].dmode;
            req.dst_logical <= cfg[first].dst_logical;
            req.dest        <= cfg[first].dest;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        grant     = '0;
        unique case (state_q)
            ST_IDLE: req_valid = 1'b0;
            ST_SEND: begin
                req_valid = 1'b1;
                for (int i = 0; i < NUM_PINS; i++) begin
                    grant[i] = req_ready && (sel == PIN_W'(i));
                end
            end
            default: req_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NUM_PINS = 4,
    parameter logic [7:0] VERSION  = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pins,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [7:0]          req_vector,
    output logic [2:0]          req_dmode,
    output logic                req_dlogical,
    output logic [7:0]          req_dest,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    redir_cfg_t          cfg_arr [NUM_PINS];
    logic [31:0]         lo_arr  [NUM_PINS];
    logic [31:0]         hi_arr  [NUM_PINS];
    logic [NUM_PINS-1:0] wr_lo_vec, wr_hi_vec, pend_vec, rirr_vec, trig_vec, grant_vec;
    logic [PIN_W-1:0]    disp_sel;
    deliv_t              req_q;

    irq_host_window #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) win_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_lo(lo_arr), .ent_hi(hi_arr),
        .wr_lo(wr_lo_vec), .wr_hi(wr_hi_vec)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        irq_redir_entry ent_i (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(wr_lo_vec[i]), .wr_hi(wr_hi_vec[i]), .wdata(bus_wdata),
            .pin_in(irq_pins[i]),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .grant(grant_vec[i]),
            .cfg(cfg_arr[i]), .pend(pend_vec[i]), .rirr(rirr_vec[i]),
            .rd_lo(lo_arr[i]), .rd_hi(hi_arr[i])
        );
        assign trig_vec[i] = cfg_arr[i].level;
    end

    irq_dispatch #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) disp_i (
        .clk(clk), .rst_n(rst_n),
        .pend(pend_vec), .cfg(cfg_arr),
        .req_ready(req_ready), .req_valid(req_valid),
        .req(req_q), .grant(grant_vec), .sel(disp_sel)
    );

    assign req_vector   = req_q.vector;
    assign req_dmode    = req_q.dmode;
    assign req_dlogical = req_q.dst_logical;
    assign req_dest     = req_q.dest;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_PINS = 4,
    parameter int PIN_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [7:0]          req_vector,
    input logic [2:0]          req_dmode,
    input logic                req_dlogical,
    input logic [7:0]          req_dest,
    input logic [NUM_PINS-1:0] grant_vec,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] trig_vec,
    input logic [NUM_PINS-1:0] rirr_vec,
    input logic [PIN_W-1:0]    disp_sel
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_vector) && $stable(req_dmode)
                                    && $stable(req_dlogical) && $stable(req_dest)); // R6

    AST_SEND_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pend_vec[disp_sel]); // R6

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R10

    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R10

    AST_LEVEL_ACK_SETS_RP: assert property (@(posedge clk) disable iff (!rst_n)
        |(grant_vec & trig_vec) |=>
            ((rirr_vec & $past(grant_vec & trig_vec)) == $past(grant_vec & trig_vec))); // R7

endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .req_dmode(req_dmode),
    .req_dlogical(req_dlogical), .req_dest(req_dest),
    .grant_vec(grant_vec), .pend_vec(pend_vec),
    .trig_vec(trig_vec), .rirr_vec(rirr_vec), .disp_sel(disp_sel)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] irq_pins = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [7:0]  req_vector, req_dest;
    logic [2:0]  req_dmode;
    logic        req_dlogical;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int checks = 0, fails = 0, deliveries = 0;
    bit ready_en = 1'b0;
    logic [19:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_PINS(NP), .VERSION(8'h20)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pins(irq_pins),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_dmode(req_dmode),
        .req_dlogical(req_dlogical), .req_dest(req_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_write(logic [7:0] idx, logic [31:0] d);
        bus_write(5'h00, {24'h0, idx});
        bus_write(5'h10, d);
    endtask

    task automatic reg_check(string tag, logic [7:0] idx, logic [31:0] exp);
        bus_write(5'h00, {24'h0, idx});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h10;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic expect_deliv(logic [7:0] v, logic [2:0] m, logic lg, logic [7:0] d);
        exp_q.push_back({v, m, lg, d});
    endtask

    task automatic drain(string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic pulse(int p, logic lvl_active, int cyc);
        @(negedge clk);
        irq_pins[p] = lvl_active;
        repeat (cyc) @(negedge clk);
        irq_pins[p] = ~lvl_active;
    endtask

    task automatic send_eoi(logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // monitor: pops expected items and compares each delivery
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid && ready_en) begin
                logic [19:0] got;
                got = {req_vector, req_dmode, req_dlogical, req_dest};
                deliveries++;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected delivery: actual=0x%05h expected=none", got);
                end else begin
                    check("R6/R10/R11 delivery fields", {12'h0, got}, {12'h0, exp_q.pop_front()});
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base;
        irq_pins[2] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 reset values
        reg_check("R1 id reset", 8'h00, 32'h0);
        reg_check("R1 arb reset", 8'h02, 32'h0);
        reg_check("R2 version", 8'h01, 32'h0003_0020);
        reg_check("R3 pin0 lo reset", 8'h10, 32'h0001_0000);
        reg_check("R3 pin3 hi reset", 8'h17, 32'h0);

        // R1 field masking
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_check("R1 id field", 8'h00, 32'h0F00_0000);
        reg_write(8'h02, 32'h5A5A_5A5A);
        reg_check("R1 arb field", 8'h02, 32'h0A00_0000);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h00; #1;
        check("R1 index readback", bus_rdata, 32'h02);
        bus_sel = 1'b0;

        // R2 read-only
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_check("R2 version write ignored", 8'h01, 32'h0003_0020);

        // program entries
        reg_write(8'h10, 32'h0000_0020);
        reg_write(8'h11, 32'h0100_0000);
        reg_write(8'h12, 32'h0000_DC41);
        reg_check("R4 ro bits ignored", 8'h12, 32'h0000_8C41);
        reg_write(8'h13, 32'h80FF_FFFF);
        reg_check("R3 hi keeps dest only", 8'h13, 32'h8000_0000);
        reg_write(8'h14, 32'h0000_2733);
        reg_write(8'h15, 32'h0500_0000);
        reg_write(8'h16, 32'h0001_0350);
        reg_write(8'h17, 32'h0A00_0000);

        // R5 R6 edge high, held request
        pulse(0, 1'b1, 2);
        repeat (3) @(negedge clk);
        reg_check("R6 status set", 8'h10, 32'h0000_1020);
        check("R6 req held valid", {31'h0, req_valid}, 32'h1);
        check("R6 req vector", {24'h0, req_vector}, 32'h20);
        expect_deliv(8'h20, 3'd0, 1'b0, 8'h01);
        ready_en = 1'b1;
        drain("R5 edge high");
        reg_check("R6 status cleared", 8'h10, 32'h0000_0020);

        // R5 R11 active-low edge, external mode
        expect_deliv(8'h33, 3'd7, 1'b0, 8'h05);
        pulse(2, 1'b0, 2);
        drain("R5 active low");

        // R8 masked pin
        base = deliveries;
        pulse(3, 1'b1, 2);
        repeat (10) @(negedge clk);
        reg_check("R8 masked no status", 8'h16, 32'h0001_0350);
        reg_write(8'h16, 32'h0000_0350);
        repeat (10) @(negedge clk);
        check("R8 masked event discarded", 32'(deliveries - base), 32'd0);
        expect_deliv(8'h50, 3'd3, 1'b0, 8'h0A);
        pulse(3, 1'b1, 2);
        drain("R11 reserved mode");

        // R7 R9 level pin
        base = deliveries;
        expect_deliv(8'h41, 3'd4, 1'b1, 8'h80);
        @(negedge clk); irq_pins[1] = 1'b1;
        drain("R7 level first");
        repeat (10) @(negedge clk);
        check("R7 single delivery while rp set", 32'(deliveries - base), 32'd1);
        reg_check("R7 remote pending set", 8'h12, 32'h0000_CC41);
        send_eoi(8'h40);
        reg_check("R9 other vector keeps rp", 8'h12, 32'h0000_CC41);
        expect_deliv(8'h41, 3'd4, 1'b1, 8'h80);
        send_eoi(8'h41);
        drain("R9 redelivery after eoi");
        check("R9 delivery count", 32'(deliveries - base), 32'd2);
        @(negedge clk); irq_pins[1] = 1'b0;
        send_eoi(8'h41);
        repeat (3) @(negedge clk);
        reg_check("R9 rp cleared", 8'h12, 32'h0000_8C41);

        // R10 priority
        ready_en = 1'b0;
        @(negedge clk);
        irq_pins[0] = 1'b1; irq_pins[2] = 1'b0;
        repeat (2) @(negedge clk);
        irq_pins[0] = 1'b0; irq_pins[2] = 1'b1;
        repeat (4) @(negedge clk);
        expect_deliv(8'h20, 3'd0, 1'b0, 8'h01);
        expect_deliv(8'h33, 3'd7, 1'b0, 8'h05);
        ready_en = 1'b1;
        drain("R10 lowest pin first");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule